// File: doc/BRIEF.md
# Sequential Field Memory Write Port Controller

This block drives the write side of a sequential field memory. On every rising edge of its write clock it samples a data word and three control lines: write enable, input enable and write reset. From these it decides what happens in that cycle:

- the word is stored at the current write address;
- the address advances but the store is suppressed, so the memory keeps its old contents;
- or nothing happens at all.

It then presents the resulting address, data and write strobe to a synchronous RAM through a register stage. The write pointer wraps from the last word back to zero, so the memory behaves as a circular field buffer.

A static polarity input selects whether the three control lines are active-high or active-low. This lets the block sit behind existing logic without glue. A write reset that arrives while writing is disabled is not lost. It is held, and it takes effect on the next cycle in which writing is enabled, and that cycle then uses address 0.

Top module: `field_wr_port`

## Requirements
- R1: The write command for a clock cycle is decided from the inputs sampled at that rising edge. It appears on `mem_we_o`, `mem_addr_o`, `mem_data_o` and `wr_ptr_o` after that same edge, and not before it.
- R2: When write enable and input enable are both active, the block issues a store.
  - `mem_we_o` is 1.
  - `mem_addr_o` is the address the pointer held before the edge.
  - `mem_data_o` is the sampled word.
  - The pointer advances by one.
- R3: When write enable is active and input enable is inactive, the cycle is masked.
  - `mem_we_o` is 0.
  - `mem_addr_o` shows the address that was skipped.
  - `mem_data_o` keeps its previous value.
  - The pointer advances by one.
- R4: When write enable is inactive, the cycle is a hold whatever the level of input enable.
  - `mem_we_o` is 0.
  - `mem_addr_o`, `mem_data_o` and the pointer keep their values.
- R5: A write reset sampled together with active write enable makes that cycle use address 0, and the pointer becomes 1. If input enable is also active, the sampled word is stored at address 0.
- R6: A write reset sampled while write enable is inactive leaves the pointer unchanged. The reset is remembered, and the next cycle with active write enable uses address 0, as in R5, even if write reset is no longer active by then.
- R7: With `pol_sel_i` = 0 the three control inputs are active-high. With `pol_sel_i` = 1 they are active-low.
- R8: The pointer counts modulo DEPTH: after address DEPTH-1 the next address used is 0.
- R9: While `rst_i` is 1 at a rising edge, the following are all cleared: `mem_we_o`, `mem_addr_o`, `mem_data_o`, the pointer, and any remembered write reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Write clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the control logic |
| pol_sel_i | input | 1 | Static control polarity: 0 active-high, 1 active-low |
| wen_i | input | 1 | Write enable (advances the pointer) |
| ien_i | input | 1 | Input enable (allows the memory store) |
| wrst_i | input | 1 | Write reset (pointer to 0) |
| din_i | input | DATA_W | Write data word |
| mem_we_o | output | 1 | Registered memory write strobe |
| mem_addr_o | output | log2(DEPTH) | Registered address of the last active cycle |
| mem_data_o | output | DATA_W | Registered data of the last store |
| wr_ptr_o | output | log2(DEPTH) | Address the next active cycle will use |

## Verification
Every result of a cycle is due exactly one rising edge after the inputs that caused it. No input-to-output path is combinational.

The bench drives each stimulus on a falling edge and waits for the next rising edge. It then compares all four outputs at the following falling edge against a model that advances once per edge. Once, it also samples just before that rising edge, to confirm that the outputs have not yet moved.

Deferred resets are followed through hold cycles of any length. Their expected address 0 is checked on the first enabled cycle that comes later.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

    // Normalized control word, all fields active-high after decoding.
    typedef struct packed {
        logic rst;
        logic ien;
        logic wen;
    } wr_ctrl_t;

    localparam int unsigned CTRL_W = $bits(wr_ctrl_t);

    // Operation selected for one write clock cycle.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_MASK  = 2'd1,
        OP_STORE = 2'd2
    } wr_op_t;

    // Convert a raw pin level into an active-high flag.
    function automatic logic to_active(input logic raw, input logic low_active);
        return raw ^ low_active;
    endfunction

    // Choose the cycle operation from normalized enables.
    function automatic wr_op_t pick_op(input logic wen, input logic ien);
        if (!wen)
            return OP_HOLD;
        else if (ien)
            return OP_STORE;
        else
            return OP_MASK;
    endfunction

endpackage

// File: rtl/fmw_polarity.sv
module fmw_polarity
    import fmw_pkg::*;
(
    input  logic [CTRL_W-1:0] raw_i,
    input  logic              low_act_i,
    output wr_ctrl_t          ctrl_o
);

    logic [CTRL_W-1:0] act;

    for (genvar g = 0; g < CTRL_W; g++) begin : g_norm
        assign act[g] = to_active(raw_i[g], low_act_i);
    end

    assign ctrl_o = wr_ctrl_t'(act);

endmodule

// File: rtl/fmw_pointer.sv
module fmw_pointer
    import fmw_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  wr_ctrl_t          ctrl_i,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [ADDR_W-1:0] ptr_o,
    output wr_op_t            op_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic              pend_q;
    logic              zero_sel;

    // A live reset or a remembered one forces this cycle to address 0.
    assign zero_sel   = ctrl_i.rst | pend_q;
    assign cmd_addr_o = zero_sel ? '0 : ptr_q;
    assign op_o       = pick_op(ctrl_i.wen, ctrl_i.ien);
    assign ptr_o      = ptr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
        end else if (ctrl_i.wen) begin
            ptr_q  <= cmd_addr_o + ADDR_W'(1);
            pend_q <= 1'b0;
        end else if (ctrl_i.rst) begin
            pend_q <= 1'b1;
        end
    end

    // R4: a disabled cycle leaves the pointer alone.
    assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_i.wen |=> $stable(ptr_q));

    // R5 / R6: an enabled cycle with a live or remembered reset lands on 1.
    assert_reset_lands_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_i.wen && (ctrl_i.rst || pend_q)) |=> (ptr_q == ADDR_W'(1)));

    // R6: a reset during a disabled cycle is remembered.
    assert_reset_held_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctrl_i.wen && (ctrl_i.rst || pend_q)) |=> pend_q);

    // R8: an enabled, non-reset cycle advances by one modulo the depth.
    assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_i.wen && !ctrl_i.rst && !pend_q) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

endmodule

// File: rtl/fmw_stage.sv
module fmw_stage
    import fmw_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  wr_op_t            op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            we_o   <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            we_o <= (op_i == OP_STORE);
            if (op_i != OP_HOLD)
                addr_o <= addr_i;
            if (op_i == OP_STORE)
                data_o <= data_i;
        end
    end

    // R2: a store cycle raises the strobe one edge later.
    assert_store_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_STORE) |=> we_o);

    // R3: a masked cycle never strobes and keeps the data.
    assert_mask_quiet_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_MASK) |=> (!we_o && $stable(data_o)));

    // R4: a hold cycle keeps address and data.
    assert_hold_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_HOLD) |=> (!we_o && $stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/field_wr_port.sv
module field_wr_port
    import fmw_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              pol_sel_i,
    input  logic              wen_i,
    input  logic              ien_i,
    input  logic              wrst_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic [ADDR_W-1:0] wr_ptr_o
);

    wr_ctrl_t          ctrl;
    wr_op_t            op;
    logic [ADDR_W-1:0] cmd_addr;

    fmw_polarity u_pol (
        .raw_i     ({wrst_i, ien_i, wen_i}),
        .low_act_i (pol_sel_i),
        .ctrl_o    (ctrl)
    );

    fmw_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ctrl_i     (ctrl),
        .cmd_addr_o (cmd_addr),
        .ptr_o      (wr_ptr_o),
        .op_o       (op)
    );

    fmw_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .op_i   (op),
        .addr_i (cmd_addr),
        .data_i (din_i),
        .we_o   (mem_we_o),
        .addr_o (mem_addr_o),
        .data_o (mem_data_o)
    );

    // R9: the cycle after a reset shows a quiet, zeroed write port.
    assert_reset_clear_R9: assert property (@(posedge clk_i)
        rst_i |=> (!mem_we_o && mem_addr_o == '0 && mem_data_o == '0 && wr_ptr_o == '0));

    // R7: the polarity select is static while running.
    assert_pol_static_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> $stable(pol_sel_i));

endmodule

// File: tb/sim_field_wr_port.sv
`timescale 1ns/1ps
module sim_field_wr_port;

    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pol = 1'b0;
    logic          wen = 1'b0, ien = 1'b0, wrst = 1'b0;
    logic [DW-1:0] din = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr, wr_ptr;
    logic [DW-1:0] mem_data;

    int checks = 0;
    int failures = 0;

    // model state
    int m_ptr = 0, m_addr = 0, m_data = 0, m_we = 0;
    bit m_pend = 0;

    always #5 clk = ~clk;

    field_wr_port #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
        .clk_i(clk), .rst_i(rst), .pol_sel_i(pol),
        .wen_i(wen), .ien_i(ien), .wrst_i(wrst), .din_i(din),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_data_o(mem_data), .wr_ptr_o(wr_ptr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "we",   int'(mem_we),   m_we);
        check(tag, "addr", int'(mem_addr), m_addr);
        check(tag, "data", int'(mem_data), m_data);
        check(tag, "ptr",  int'(wr_ptr),   m_ptr);
    endtask

    // Called at a falling edge; arguments are logical (active-high) levels.
    task automatic step(input bit w, input bit i, input bit r, input int d, input string tag);
        wen  = w ^ pol;
        ien  = i ^ pol;
        wrst = r ^ pol;
        din  = DW'(d);
        @(posedge clk);
        if (w) begin
            int use_a;
            use_a  = (r || m_pend) ? 0 : m_ptr;
            m_addr = use_a;
            m_we   = i ? 1 : 0;
            if (i) m_data = d % (1 << DW);
            m_ptr  = (use_a + 1) % DEPTH;
            m_pend = 0;
        end else begin
            m_we = 0;
            if (r) m_pend = 1;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset(input bit new_pol);
        rst  = 1'b1;
        pol  = new_pol;
        wen  = new_pol; ien = new_pol; wrst = new_pol;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 0; m_addr = 0; m_data = 0; m_we = 0; m_pend = 0;
        check_all("R9");
    endtask

    initial begin
        #(10 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        @(negedge clk);
        do_reset(1'b0);

        // R1: outputs must not move before the sampling edge
        wen = 1'b1; ien = 1'b1; wrst = 1'b1; din = 8'hA5;
        #1;
        check("R1", "we_before_edge", int'(mem_we), 0);
        check("R1", "ptr_before_edge", int'(wr_ptr), 0);
        @(negedge clk);
        wen = 1'b0; ien = 1'b0; wrst = 1'b0;
        do_reset(1'b0);

        // R5: write reset with store
        step(1, 1, 1, 8'h3C, "R5");
        // R2 and R8: long store run crossing the wrap
        for (int k = 0; k < DEPTH + 3; k++)
            step(1, 1, 0, k * 7 + 3, "R8");
        // R3: masked cycles
        for (int k = 0; k < 3; k++)
            step(1, 0, 0, 8'hEE, "R3");
        step(1, 1, 0, 8'h11, "R2");
        // R4: holds with input enable either way
        step(0, 1, 0, 8'h22, "R4");
        step(0, 0, 0, 8'h33, "R4");
        // R6: deferred reset through holds, then a masked cycle, then store
        step(0, 1, 1, 8'h44, "R6");
        step(0, 0, 0, 8'h45, "R6");
        step(0, 1, 0, 8'h46, "R6");
        step(1, 0, 0, 8'h47, "R6");
        step(1, 1, 0, 8'h48, "R6");
        // R6: deferred reset then a direct store at address 0
        step(0, 0, 1, 8'h50, "R6");
        step(1, 1, 0, 8'h51, "R6");
        // R5: masked write reset
        step(1, 1, 0, 8'h52, "R2");
        step(1, 0, 1, 8'h53, "R5");

        // R9: synchronous reset mid-run, then sweep active-high
        do_reset(1'b0);
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2] & lfsr[3], int'(lfsr[15:8]), "R7");
        end

        // R7: active-low polarity, exhaustive combinations then sweep
        do_reset(1'b1);
        for (int c = 0; c < 8; c++)
            for (int rep = 0; rep < 3; rep++)
                step(c[0], c[1], c[2], c * 16 + rep, "R7");
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2] & lfsr[3], int'(lfsr[15:8]), "R7");
        end
        for (int k = 0; k < DEPTH + 2; k++)
            step(1, k[0], 0, k, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule